// File: doc/BRIEF.md
# Multiplexed Command Decoder with Bank Tracking

This block sits behind the command/address pins of a DDR4-style memory device, or in a controller model that must follow what the device thinks is open. It samples the bus on each rising clock edge. A dedicated row-strobe pin decides how three shared pins are read. When the strobe is low, the three pins are the top three row-address bits and the cycle is an activate. When the strobe is high, the same three pins are command controls, and together they encode read, write, precharge, refresh or no-operation.

Banks are addressed in two levels: a bank-group field and a bank-within-group field. The `DEV_WIDTH` parameter selects the organisation. Widths 4 and 8 give four groups of four banks. Width 16 gives two groups of four banks. Each bank has a two-state machine with the states `SLOT_CLOSED` and `SLOT_OPEN`. The transition `open` (an activate to a closed bank) latches the row. The transition `close` (a single precharge to that bank, or a precharge-all) clears it.

The decoded command, its address, its bank index and a protocol-error flag are registered. All of them appear in the cycle after the sampling edge. The same edge updates the open-row table.

Top module: `mux_cmd_tracker`

## Requirements
- R1: After reset, every bank reads closed with row 0, `cmd_o` is 0 (deselect), `addr_o` and `bank_o` are 0, and `proto_err_o` is low.
- R2: With `chip_sel_n_i` high on an edge, whatever the other inputs are, the next cycle shows `cmd_o`=0 with `addr_o`=0 and `bank_o`=0, and no bank changes state or row.
- R3: With `chip_sel_n_i` low and `row_strobe_n_i` low, the cycle is an activate. The next cycle shows `cmd_o`=2, and `addr_o` = {`mux_hi_i`[2], `mux_hi_i`[1], `mux_hi_i`[0], `addr_lo_i`}, so `mux_hi_i`[2] is row bit 16. If the addressed bank was closed, it opens with that row.
- R4: With the row strobe high, `mux_hi_i`=3'b101 is a read (`cmd_o`=3) and 3'b100 is a write (`cmd_o`=4). For both, `addr_o` carries `addr_lo_i`[9:0] zero-extended and `bank_o` carries the bank index. The bank table does not change.
- R5: `mux_hi_i`=3'b010 with `addr_lo_i`[10] low is a single precharge (`cmd_o`=5). It closes only the addressed bank and sets its row to 0. Precharging a bank that is already closed is not an error.
- R6: `mux_hi_i`=3'b010 with `addr_lo_i`[10] high is a precharge-all (`cmd_o`=6). It closes every bank and reports `addr_o`=0 and `bank_o`=0.
- R7: `mux_hi_i`=3'b001 is a refresh (`cmd_o`=7). The patterns 3'b111, 3'b110, 3'b011 and 3'b000 decode as no-operation (`cmd_o`=1). Neither a refresh nor a no-operation changes any bank, and both report `addr_o`=0 and `bank_o`=0.
- R8: An activate to an open bank, or a read or write to a closed bank, drives `proto_err_o` high for the cycle in which that command is reported. In the error case the open state and the row of the addressed bank stay as they were.
- R9: The bank index is {`grp_i`, `bnk_i`}, so bank = group*4 + bank-in-group. `grp_i` is 2 bits wide for widths 4 and 8 (16 banks) and 1 bit wide for width 16 (8 banks). Bit b of `bank_open_o` belongs to bank b, and bits [b*17 +: 17] of `bank_row_o` hold its row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel_n_i | input | 1 | Active-low chip select; high means deselect |
| row_strobe_n_i | input | 1 | Low marks an activate and turns the shared pins into row bits |
| mux_hi_i | input | 3 | Shared pins: row bits 16..14 on activate, command controls otherwise |
| addr_lo_i | input | 14 | Address bits 13..0 |
| grp_i | input | BG_W (2 or 1) | Bank-group field |
| bnk_i | input | 2 | Bank within group |
| cmd_o | output | 3 | Decoded command code |
| addr_o | output | 17 | Row (activate) or column (read/write) address |
| bank_o | output | IDX_W | Bank index of the reported command |
| proto_err_o | output | 1 | Protocol-error pulse |
| bank_open_o | output | NUM_BANKS | Per-bank open flag |
| bank_row_o | output | NUM_BANKS*17 | Per-bank open row, 0 when closed |

## Verification
In one cycle the block can both flag a protocol violation and decide whether the table must change. The sharpest case is an activate to a bank that is already open: the error must rise while the stored row must stay. The bench provokes this by activating a bank a second time with a different row. It then requires, on the same reporting cycle, the error flag, the new command code and the unchanged old row. A read to a bank that was just closed by a single precharge is treated the same way, and the neighbouring bank must stay untouched.

// File: rtl/mct_pkg.sv
`timescale 1ns/1ps
package mct_pkg;

    // Command codes reported on cmd_o
    typedef enum logic [2:0] {
        OP_DESEL     = 3'd0,
        OP_NOP       = 3'd1,
        OP_ACTIVATE  = 3'd2,
        OP_READ      = 3'd3,
        OP_WRITE     = 3'd4,
        OP_CLOSE     = 3'd5,
        OP_CLOSE_ALL = 3'd6,
        OP_REFRESH   = 3'd7
    } op_e;

    // Per-bank state
    typedef enum logic {
        SLOT_CLOSED = 1'b0,
        SLOT_OPEN   = 1'b1
    } slot_e;

    // Control patterns on the shared pins when the row strobe is high
    localparam logic [2:0] PAT_READ    = 3'b101;
    localparam logic [2:0] PAT_WRITE   = 3'b100;
    localparam logic [2:0] PAT_CLOSE   = 3'b010;
    localparam logic [2:0] PAT_REFRESH = 3'b001;

endpackage

// File: rtl/mct_field_split.sv
`timescale 1ns/1ps
module mct_field_split #(
    parameter int LO_W     = 14,
    parameter int COL_W    = 10,
    parameter int IDX_W    = 4,
    parameter int ALL_BIT  = 10,
    localparam int ROW_W   = LO_W + 3
) (
    input  logic             sel_n,
    input  logic             strobe_n,
    input  logic [2:0]       hi,
    input  logic [LO_W-1:0]  lo,
    input  logic [IDX_W-1:0] idx,
    output mct_pkg::op_e     op,
    output logic [ROW_W-1:0] addr_out,
    output logic [IDX_W-1:0] idx_out
);
    import mct_pkg::*;

    always_comb begin
        op       = OP_DESEL;
        addr_out = '0;
        idx_out  = '0;
        if (!sel_n) begin
            if (!strobe_n) begin
                op       = OP_ACTIVATE;
                addr_out = {hi, lo};
                idx_out  = idx;
            end else begin
                unique case (hi)
                    PAT_READ: begin
                        op       = OP_READ;
                        addr_out = ROW_W'(lo[COL_W-1:0]);
                        idx_out  = idx;
                    end
                    PAT_WRITE: begin
                        op       = OP_WRITE;
                        addr_out = ROW_W'(lo[COL_W-1:0]);
                        idx_out  = idx;
                    end
                    PAT_CLOSE: begin
                        if (lo[ALL_BIT]) begin
                            op = OP_CLOSE_ALL;
                        end else begin
                            op      = OP_CLOSE;
                            idx_out = idx;
                        end
                    end
                    PAT_REFRESH: op = OP_REFRESH;
                    default:     op = OP_NOP;
                endcase
            end
        end
    end

endmodule

// File: rtl/mct_bank_slot.sv
`timescale 1ns/1ps
module mct_bank_slot #(
    parameter int ROW_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_req,
    input  logic             close_req,
    input  logic [ROW_W-1:0] row_in,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o
);
    import mct_pkg::*;

    slot_e            state_q, state_d;
    logic [ROW_W-1:0] row_q;

    // State register and stored row
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_CLOSED;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SLOT_CLOSED && open_req) begin
                row_q <= row_in;
            end else if (state_q == SLOT_OPEN && close_req) begin
                row_q <= '0;
            end
        end
    end

    // Transitions: open (closed -> open), close (open -> closed)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_CLOSED: if (open_req)  state_d = SLOT_OPEN;
            SLOT_OPEN:   if (close_req) state_d = SLOT_CLOSED;
            default:     state_d = SLOT_CLOSED;
        endcase
    end

    // Outputs
    always_comb begin
        open_o = (state_q == SLOT_OPEN);
        row_o  = row_q;
    end

endmodule

// File: rtl/mux_cmd_tracker.sv
`timescale 1ns/1ps
module mux_cmd_tracker #(
    parameter int DEV_WIDTH  = 8,
    parameter int LO_W       = 14,
    parameter int COL_W      = 10,
    parameter int BA_W       = 2,
    localparam int BG_W      = (DEV_WIDTH == 16) ? 1 : 2,
    localparam int IDX_W     = BG_W + BA_W,
    localparam int NUM_BANKS = 1 << IDX_W,
    localparam int ROW_W     = LO_W + 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       chip_sel_n_i,
    input  logic                       row_strobe_n_i,
    input  logic [2:0]                 mux_hi_i,
    input  logic [LO_W-1:0]            addr_lo_i,
    input  logic [BG_W-1:0]            grp_i,
    input  logic [BA_W-1:0]            bnk_i,
    output logic [2:0]                 cmd_o,
    output logic [ROW_W-1:0]           addr_o,
    output logic [IDX_W-1:0]           bank_o,
    output logic                       proto_err_o,
    output logic [NUM_BANKS-1:0]       bank_open_o,
    output logic [NUM_BANKS*ROW_W-1:0] bank_row_o
);
    import mct_pkg::*;

    localparam int ALL_BIT = 10;

    op_e              op_d;
    logic [ROW_W-1:0] addr_d;
    logic [IDX_W-1:0] idx_d;
    logic             hit_open;
    logic             err_d;

    mct_field_split #(
        .LO_W    (LO_W),
        .COL_W   (COL_W),
        .IDX_W   (IDX_W),
        .ALL_BIT (ALL_BIT)
    ) u_split (
        .sel_n    (chip_sel_n_i),
        .strobe_n (row_strobe_n_i),
        .hi       (mux_hi_i),
        .lo       (addr_lo_i),
        .idx      ({grp_i, bnk_i}),
        .op       (op_d),
        .addr_out (addr_d),
        .idx_out  (idx_d)
    );

    // Bank table, one state machine per bank
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_slot
        logic open_req;
        logic close_req;
        assign open_req  = (op_d == OP_ACTIVATE) && (idx_d == IDX_W'(b));
        assign close_req = ((op_d == OP_CLOSE) && (idx_d == IDX_W'(b)))
                         || (op_d == OP_CLOSE_ALL);
        mct_bank_slot #(.ROW_W(ROW_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .open_req  (open_req),
            .close_req (close_req),
            .row_in    (addr_d),
            .open_o    (bank_open_o[b]),
            .row_o     (bank_row_o[b*ROW_W +: ROW_W])
        );
    end

    // Protocol check against the table as it stood before this edge
    always_comb begin
        hit_open = bank_open_o[idx_d];
        unique case (op_d)
            OP_ACTIVATE:      err_d = hit_open;
            OP_READ, OP_WRITE: err_d = !hit_open;
            default:          err_d = 1'b0;
        endcase
    end

    // Registered command report
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_o       <= OP_DESEL;
            addr_o      <= '0;
            bank_o      <= '0;
            proto_err_o <= 1'b0;
        end else begin
            cmd_o       <= op_d;
            addr_o      <= addr_d;
            bank_o      <= idx_d;
            proto_err_o <= err_d;
        end
    end

endmodule

// File: rtl/mux_cmd_tracker_chk.sv
`timescale 1ns/1ps
module mux_cmd_tracker_chk #(
    parameter int IDX_W     = 4,
    parameter int NUM_BANKS = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 chip_sel_n_i,
    input logic [2:0]           cmd_o,
    input logic [IDX_W-1:0]     bank_o,
    input logic                 proto_err_o,
    input logic [NUM_BANKS-1:0] bank_open_o
);

    assert_desel_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chip_sel_n_i |=> (cmd_o == 3'd0) && $stable(bank_open_o));

    assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 3'd2) |-> bank_open_o[bank_o]);

    assert_close_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 3'd5) |-> !bank_open_o[bank_o]);

    assert_close_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 3'd6) |-> (bank_open_o == '0));

    assert_access_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o == 3'd3 || cmd_o == 3'd4) && !proto_err_o) |-> bank_open_o[bank_o]);

    assert_err_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |-> (cmd_o == 3'd2 || cmd_o == 3'd3 || cmd_o == 3'd4));

    assert_refresh_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 3'd7 || cmd_o == 3'd1) |-> $stable(bank_open_o));

endmodule

bind mux_cmd_tracker mux_cmd_tracker_chk #(
    .IDX_W     (IDX_W),
    .NUM_BANKS (NUM_BANKS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chip_sel_n_i (chip_sel_n_i),
    .cmd_o        (cmd_o),
    .bank_o       (bank_o),
    .proto_err_o  (proto_err_o),
    .bank_open_o  (bank_open_o)
);

// File: tb/tb_mux_cmd_tracker.sv
`timescale 1ns/1ps
module tb_mux_cmd_tracker;

    localparam int NB    = 16;
    localparam int ROW_W = 17;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel_n = 1'b1;
    logic              strobe_n = 1'b1;
    logic [2:0]        hi = 3'b111;
    logic [13:0]       lo = '0;
    logic [1:0]        grp = '0;
    logic [1:0]        bnk = '0;
    logic [2:0]        cmd;
    logic [ROW_W-1:0]  addr;
    logic [3:0]        bank;
    logic              err;
    logic [NB-1:0]     open_v;
    logic [NB*ROW_W-1:0] rows;

    int checks = 0;
    int errors = 0;

    logic              m_open [NB];
    logic [ROW_W-1:0]  m_row  [NB];

    always #10 clk = ~clk;

    mux_cmd_tracker dut (
        .clk(clk), .rst_n(rst_n), .chip_sel_n_i(sel_n), .row_strobe_n_i(strobe_n),
        .mux_hi_i(hi), .addr_lo_i(lo), .grp_i(grp), .bnk_i(bnk),
        .cmd_o(cmd), .addr_o(addr), .bank_o(bank), .proto_err_o(err),
        .bank_open_o(open_v), .bank_row_o(rows)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_table(input string req);
        for (int b = 0; b < NB; b++) begin
            check(req, $sformatf("open[%0d]", b), 32'(open_v[b]), 32'(m_open[b]));
            check(req, $sformatf("row[%0d]", b), 32'(rows[b*ROW_W +: ROW_W]), 32'(m_row[b]));
        end
    endtask

    function automatic logic [ROW_W-1:0] row_pat(input int i, input int salt);
        return ROW_W'(i * 17'h0B5A3 + salt * 17'h04C1 + 17'h10041);
    endfunction

    // One command: drive at falling edge, report after the next rising edge
    task automatic issue(input string req, input logic s_n, input logic st_n,
                         input logic [2:0] h, input logic [13:0] l, input int idx);
        logic [2:0]       e_cmd;
        logic [ROW_W-1:0] e_addr;
        logic [3:0]       e_bank;
        logic             e_err;
        logic [3:0]       ix;
        ix = 4'(idx);
        @(negedge clk);
        sel_n = s_n; strobe_n = st_n; hi = h; lo = l; grp = ix[3:2]; bnk = ix[1:0];
        e_cmd = 3'd0; e_addr = '0; e_bank = '0; e_err = 1'b0;
        if (!s_n) begin
            if (!st_n) begin
                e_cmd = 3'd2; e_addr = {h, l}; e_bank = ix; e_err = m_open[ix];
                if (!m_open[ix]) begin m_open[ix] = 1'b1; m_row[ix] = {h, l}; end
            end else begin
                case (h)
                    3'b101, 3'b100: begin
                        e_cmd = (h == 3'b101) ? 3'd3 : 3'd4;
                        e_addr = ROW_W'(l[9:0]); e_bank = ix; e_err = !m_open[ix];
                    end
                    3'b010: begin
                        if (l[10]) begin
                            e_cmd = 3'd6;
                            for (int b = 0; b < NB; b++) begin m_open[b] = 1'b0; m_row[b] = '0; end
                        end else begin
                            e_cmd = 3'd5; e_bank = ix; m_open[ix] = 1'b0; m_row[ix] = '0;
                        end
                    end
                    3'b001:  e_cmd = 3'd7;
                    default: e_cmd = 3'd1;
                endcase
            end
        end
        @(posedge clk);
        #1;
        check(req, "cmd", 32'(cmd), 32'(e_cmd));
        check(req, "addr", 32'(addr), 32'(e_addr));
        check(req, "bank", 32'(bank), 32'(e_bank));
        check("R8", "err", 32'(err), 32'(e_err));
        check_table(req);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) begin m_open[b] = 1'b0; m_row[b] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1", "cmd", 32'(cmd), 32'd0);
        check("R1", "addr", 32'(addr), 32'd0);
        check("R1", "bank", 32'(bank), 32'd0);
        check("R1", "err", 32'(err), 32'd0);
        check_table("R1");

        // R4 R5 R6 R7 R8: all control patterns with every bank closed
        for (int p = 0; p < 8; p++)
            issue("R7", 1'b0, 1'b1, 3'(p), 14'(p * 16'h0257), p);
        issue("R6", 1'b0, 1'b1, 3'b010, 14'h0400, 9);

        // R3 R9: open every bank with its own row
        for (int i = 0; i < NB; i++) begin
            logic [ROW_W-1:0] r;
            r = row_pat(i, 0);
            issue("R3", 1'b0, 1'b0, r[16:14], r[13:0], i);
        end

        // R2: deselect sweep with every strobe and pattern, banks open
        for (int p = 0; p < 16; p++)
            issue("R2", 1'b1, p[3], 3'(p), 14'h0400 | 14'(p), p);

        // R8: second activate to open bank 3 keeps its row
        begin
            logic [ROW_W-1:0] r;
            r = row_pat(3, 5);
            issue("R8", 1'b0, 1'b0, r[16:14], r[13:0], 3);
        end

        // R4: reads and writes to every open bank
        for (int i = 0; i < NB; i++) begin
            issue("R4", 1'b0, 1'b1, 3'b101, 14'(16'h3C00 | 16'(i * 41)), i);
            issue("R4", 1'b0, 1'b1, 3'b100, 14'(16'h0400 | 16'(i * 59)), i);
        end

        // R7: refresh and no-operation with banks open
        issue("R7", 1'b0, 1'b1, 3'b001, 14'h1555, 2);
        issue("R7", 1'b0, 1'b1, 3'b111, 14'h2AAA, 7);
        issue("R7", 1'b0, 1'b1, 3'b000, 14'h0400, 12);

        // R5: single close of bank 5, neighbours stay
        issue("R5", 1'b0, 1'b1, 3'b010, 14'h0000, 5);
        issue("R8", 1'b0, 1'b1, 3'b101, 14'h0011, 5);
        issue("R4", 1'b0, 1'b1, 3'b100, 14'h0022, 6);
        issue("R5", 1'b0, 1'b1, 3'b010, 14'h3BFF, 5);
        issue("R9", 1'b0, 1'b1, 3'b010, 14'h0000, 14);

        // R6: close all, then reuse
        issue("R6", 1'b0, 1'b1, 3'b010, 14'h0400, 0);
        issue("R8", 1'b0, 1'b1, 3'b100, 14'h0033, 0);
        begin
            logic [ROW_W-1:0] r;
            r = row_pat(0, 9);
            issue("R3", 1'b0, 1'b0, r[16:14], r[13:0], 0);
            r = row_pat(15, 2);
            issue("R9", 1'b0, 1'b0, r[16:14], r[13:0], 15);
        end
        issue("R4", 1'b0, 1'b1, 3'b101, 14'h03FF, 15);
        issue("R2", 1'b1, 1'b1, 3'b010, 14'h0400, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule